// File: doc/BRIEF.md
# Configuration Stream Loader with In-Stream CRC

The loader takes a byte-wide configuration stream from a host and writes each payload byte to a frame store write port, one address per byte in arrival order. While the payload arrives it folds every byte into a running CRC-16. The payload length is a parameter. The two bytes that follow the payload carry the CRC the host expects. When the last of them arrives, the loader compares it with its own result.

On a match the loader raises its done bit. A loader that ends the chain then refuses further data. A loader in the middle of a chain forwards every later byte to the next device on a downstream data port.

On a mismatch, or when the frame store reports a write fault during loading, the active-low init line falls. The loader then stays in configuration until reset. The host is held off by a busy output. Pulling either of two active-low chip-select inputs low pauses the transfer and freezes the master configuration clock output.

Top module: `cfg_stream_loader`

## Requirements
- R1: While reset is high and in the cycle after it is released, `init_n` is 1, `done_bit` is 0, `fs_wr_en` is 0 and `ds_valid` is 0. With both chip selects high, `host_busy` is 0.
- R2: While `cs_a_n` or `cs_b_n` is 0, `host_busy` is 1. A byte offered with `host_valid` in such a cycle is not accepted, so no frame store write follows it.
- R3: `cfg_mclk` holds its level across a clock edge at which a chip select is low. It changes level at every edge at which both chip selects are high.
- R4: The k-th accepted payload byte (k from 0) is written one cycle after acceptance: `fs_wr_en` is 1, `fs_addr` is k and `fs_wdata` is the byte.
- R5: The CRC is CRC-16 with polynomial 0x8005 and seed 0x0000, run over the payload bytes only, most significant bit first. After `PAYLOAD_BYTES` payload bytes, the next accepted byte is the high byte of the expected CRC and the one after it is the low byte. On a match, `done_bit` is 1 from the cycle after the low byte is accepted.
- R6: On a CRC mismatch, `init_n` is 0 from the cycle after the low CRC byte is accepted. `done_bit` stays 0, `host_busy` stays 1 and later bytes cause no writes until reset.
- R7: `fs_wr_err` high in any cycle before the CRC check completes drives `init_n` to 0 in the next cycle. The same rules as a mismatch then apply. The fault takes priority over a byte accepted in the same cycle, including a correct final CRC byte, and suppresses that byte's write.
- R8: With `chain_last` = 1, after a match `host_busy` stays 1, and an offered byte produces neither a frame store write nor a downstream strobe.
- R9: With `chain_last` = 0, after a match every accepted byte appears on `ds_data` with `ds_valid` = 1 one cycle after acceptance, and `fs_wr_en` stays 0.
- R10: A synchronous reset in the middle of a stream returns the loader to idle. `init_n` is 1, `done_bit` is 0, and the next payload byte is written to address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| host_data | input | 8 | Stream byte from the host |
| host_valid | input | 1 | Host offers `host_data` this cycle |
| host_busy | output | 1 | Loader cannot accept a byte this cycle |
| cs_a_n | input | 1 | Chip select A, active low; low pauses loading |
| cs_b_n | input | 1 | Chip select B, active low; low pauses loading |
| chain_last | input | 1 | 1: last or only device; 0: forward data after a match |
| fs_wr_err | input | 1 | Frame store reports a write fault |
| fs_wr_en | output | 1 | Frame store write strobe |
| fs_addr | output | $clog2(PAYLOAD_BYTES) | Frame store write address |
| fs_wdata | output | 8 | Frame store write data |
| ds_data | output | 8 | Byte forwarded to the downstream device |
| ds_valid | output | 1 | `ds_data` is valid |
| cfg_mclk | output | 1 | Master configuration clock, frozen while paused |
| init_n | output | 1 | Active-low error indication |
| done_bit | output | 1 | Stream loaded and CRC matched |

## Verification
The two functions that can meet in one cycle are the final CRC check and a frame store write fault. The bench offers a correct low CRC byte with `fs_wr_err` high in the same cycle. It expects `init_n` low and `done_bit` still 0 in the next cycle. A second coincidence is a chip select falling in the same cycle the host offers a byte. In that case the bench expects no write, a frozen `cfg_mclk`, and the byte to be taken only when it is offered again.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_CRC_HI,
    ST_CRC_LO,
    ST_DONE,
    ST_PASS,
    ST_ERR
  } ld_state_e;

  localparam logic [15:0] CRC_POLY = 16'h8005;
  localparam logic [15:0] CRC_SEED = 16'h0000;

  // One byte of CRC-16, most significant data bit first
  function automatic logic [15:0] crc16_step(input logic [15:0] c,
                                             input logic [7:0] b,
                                             input logic [15:0] poly);
    logic [15:0] r;
    logic        fb;
    r = c;
    for (int i = 7; i >= 0; i--) begin
      fb = r[15] ^ b[i];
      r  = {r[14:0], 1'b0};
      if (fb) r = r ^ poly;
    end
    return r;
  endfunction

endpackage

// File: rtl/cfg_crc_engine.sv
module cfg_crc_engine
  import cfg_loader_pkg::*;
#(
  parameter logic [15:0] POLY = CRC_POLY,
  parameter logic [15:0] SEED = CRC_SEED
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        upd,
  input  logic [7:0]  din,
  output logic [15:0] crc
);

  logic [15:0] crc_q;

  always_ff @(posedge clk) begin
    if (rst) crc_q <= SEED;
    else if (upd) crc_q <= crc16_step(crc_q, din, POLY);
  end

  assign crc = crc_q;

  // Payload CRC must not move on cycles with no payload byte
  assert_crc_frozen_R5: assert property (@(posedge clk) disable iff (rst)
    !upd |=> $stable(crc_q));

endmodule

// File: rtl/cfg_mclk_gen.sv
module cfg_mclk_gen (
  input  logic clk,
  input  logic rst,
  input  logic hold,
  output logic mclk
);

  logic mclk_q;

  always_ff @(posedge clk) begin
    if (rst) mclk_q <= 1'b0;
    else if (!hold) mclk_q <= ~mclk_q;
  end

  assign mclk = mclk_q;

  assert_mclk_frozen_R3: assert property (@(posedge clk) disable iff (rst)
    hold |=> $stable(mclk_q));

  assert_mclk_runs_R3: assert property (@(posedge clk) disable iff (rst)
    !hold |=> (mclk_q != $past(mclk_q)));

endmodule

// File: rtl/cfg_chain_fwd.sv
module cfg_chain_fwd #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fwd,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] ds_data,
  output logic          ds_valid
);

  logic [DW-1:0] data_q;
  logic          vld_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      vld_q <= fwd;
      if (fwd) data_q <= din;
    end
  end

  assign ds_data  = data_q;
  assign ds_valid = vld_q;

endmodule

// File: rtl/cfg_loader_ctrl.sv
module cfg_loader_ctrl
  import cfg_loader_pkg::*;
#(
  parameter int PAYLOAD_BYTES = 16,
  localparam int ADDR_W = (PAYLOAD_BYTES > 2) ? $clog2(PAYLOAD_BYTES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [7:0]        host_data,
  input  logic              host_valid,
  input  logic              cs_a_n,
  input  logic              cs_b_n,
  input  logic              chain_last,
  input  logic              fs_wr_err,
  input  logic [15:0]       crc_value,
  output logic              host_busy,
  output logic              paused,
  output logic              payload_acc,
  output logic              pass_acc,
  output logic              fs_wr_en,
  output logic [ADDR_W-1:0] fs_addr,
  output logic [7:0]        fs_wdata,
  output logic              init_n,
  output logic              done_bit
);

  localparam logic [ADDR_W-1:0] LAST_IDX = ADDR_W'(PAYLOAD_BYTES - 1);

  ld_state_e         state_q;
  logic [ADDR_W-1:0] cnt_q;
  logic [7:0]        exp_hi_q;
  logic              init_n_q;
  logic              done_q;
  logic              wr_q;
  logic [ADDR_W-1:0] addr_q;
  logic [7:0]        wdata_q;

  // Named internal events
  logic accept;
  logic in_cfg;
  logic err_hit;
  logic crc_ok;

  always_comb begin
    paused  = !cs_a_n || !cs_b_n;
    host_busy = paused || (state_q == ST_DONE) || (state_q == ST_ERR);
    accept  = host_valid && !host_busy;
    in_cfg  = (state_q == ST_IDLE) || (state_q == ST_LOAD) ||
              (state_q == ST_CRC_HI) || (state_q == ST_CRC_LO);
    err_hit = fs_wr_err && in_cfg;
    payload_acc = accept && !err_hit &&
                  ((state_q == ST_IDLE) || (state_q == ST_LOAD));
    pass_acc = accept && (state_q == ST_PASS);
    crc_ok   = ({exp_hi_q, host_data} == crc_value);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      cnt_q    <= '0;
      exp_hi_q <= '0;
      init_n_q <= 1'b1;
      done_q   <= 1'b0;
      wr_q     <= 1'b0;
      addr_q   <= '0;
      wdata_q  <= '0;
    end else begin
      wr_q <= payload_acc;
      if (payload_acc) begin
        addr_q  <= cnt_q;
        wdata_q <= host_data;
      end
      if (err_hit) begin
        state_q  <= ST_ERR;
        init_n_q <= 1'b0;
      end else if (accept) begin
        case (state_q)
          ST_IDLE, ST_LOAD: begin
            cnt_q   <= cnt_q + 1'b1;
            state_q <= (cnt_q == LAST_IDX) ? ST_CRC_HI : ST_LOAD;
          end
          ST_CRC_HI: begin
            exp_hi_q <= host_data;
            state_q  <= ST_CRC_LO;
          end
          ST_CRC_LO: begin
            if (crc_ok) begin
              done_q  <= 1'b1;
              state_q <= chain_last ? ST_DONE : ST_PASS;
            end else begin
              init_n_q <= 1'b0;
              state_q  <= ST_ERR;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign fs_wr_en = wr_q;
  assign fs_addr  = addr_q;
  assign fs_wdata = wdata_q;
  assign init_n   = init_n_q;
  assign done_bit = done_q;

  assert_pause_no_write_R2: assert property (@(posedge clk) disable iff (rst)
    paused |=> !wr_q);

  assert_err_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    !init_n_q |=> (!init_n_q && !done_q && host_busy));

  assert_done_not_err_R5: assert property (@(posedge clk) disable iff (rst)
    !(done_q && !init_n_q));

  assert_write_only_loading_R4: assert property (@(posedge clk) disable iff (rst)
    wr_q |-> ((state_q == ST_LOAD) || (state_q == ST_CRC_HI)));

  assert_pass_no_write_R9: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_PASS) |=> !wr_q);

endmodule

// File: rtl/cfg_stream_loader.sv
module cfg_stream_loader
  import cfg_loader_pkg::*;
#(
  parameter int PAYLOAD_BYTES = 16,
  localparam int ADDR_W = (PAYLOAD_BYTES > 2) ? $clog2(PAYLOAD_BYTES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [7:0]        host_data,
  input  logic              host_valid,
  output logic              host_busy,
  input  logic              cs_a_n,
  input  logic              cs_b_n,
  input  logic              chain_last,
  input  logic              fs_wr_err,
  output logic              fs_wr_en,
  output logic [ADDR_W-1:0] fs_addr,
  output logic [7:0]        fs_wdata,
  output logic [7:0]        ds_data,
  output logic              ds_valid,
  output logic              cfg_mclk,
  output logic              init_n,
  output logic              done_bit
);

  logic [15:0] crc_value;
  logic        paused;
  logic        payload_acc;
  logic        pass_acc;

  cfg_loader_ctrl #(.PAYLOAD_BYTES(PAYLOAD_BYTES)) ctrl_i (
    .clk(clk), .rst(rst),
    .host_data(host_data), .host_valid(host_valid),
    .cs_a_n(cs_a_n), .cs_b_n(cs_b_n),
    .chain_last(chain_last), .fs_wr_err(fs_wr_err),
    .crc_value(crc_value),
    .host_busy(host_busy), .paused(paused),
    .payload_acc(payload_acc), .pass_acc(pass_acc),
    .fs_wr_en(fs_wr_en), .fs_addr(fs_addr), .fs_wdata(fs_wdata),
    .init_n(init_n), .done_bit(done_bit)
  );

  cfg_crc_engine #(.POLY(CRC_POLY), .SEED(CRC_SEED)) crc_i (
    .clk(clk), .rst(rst), .upd(payload_acc), .din(host_data), .crc(crc_value)
  );

  cfg_mclk_gen mclk_i (
    .clk(clk), .rst(rst), .hold(paused), .mclk(cfg_mclk)
  );

  cfg_chain_fwd #(.DW(8)) fwd_i (
    .clk(clk), .rst(rst), .fwd(pass_acc), .din(host_data),
    .ds_data(ds_data), .ds_valid(ds_valid)
  );

  assert_ds_after_done_R9: assert property (@(posedge clk) disable iff (rst)
    ds_valid |-> done_bit);

endmodule

// File: tb/cfg_stream_loader_tb.sv
module cfg_stream_loader_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int N = 16;
  localparam int AW = $clog2(N);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [7:0]    host_data = '0;
  logic          host_valid = 1'b0;
  logic          host_busy;
  logic          cs_a_n = 1'b1;
  logic          cs_b_n = 1'b1;
  logic          chain_last = 1'b1;
  logic          fs_wr_err = 1'b0;
  logic          fs_wr_en;
  logic [AW-1:0] fs_addr;
  logic [7:0]    fs_wdata;
  logic [7:0]    ds_data;
  logic          ds_valid;
  logic          cfg_mclk;
  logic          init_n;
  logic          done_bit;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;
  logic [7:0] pl [N];

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_stream_loader #(.PAYLOAD_BYTES(N)) dut_i (
    .clk(clk), .rst(rst), .host_data(host_data), .host_valid(host_valid),
    .host_busy(host_busy), .cs_a_n(cs_a_n), .cs_b_n(cs_b_n),
    .chain_last(chain_last), .fs_wr_err(fs_wr_err),
    .fs_wr_en(fs_wr_en), .fs_addr(fs_addr), .fs_wdata(fs_wdata),
    .ds_data(ds_data), .ds_valid(ds_valid), .cfg_mclk(cfg_mclk),
    .init_n(init_n), .done_bit(done_bit)
  );

  // CRC restated as a shift register with the byte preloaded into the top
  function automatic logic [15:0] ref_crc();
    logic [15:0] c = 16'h0000;
    for (int i = 0; i < N; i++) begin
      c = c ^ {pl[i], 8'h00};
      for (int k = 0; k < 8; k++)
        c = c[15] ? ((c << 1) ^ 16'h8005) : (c << 1);
    end
    return c;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; host_valid = 1'b0; fs_wr_err = 1'b0;
    cs_a_n = 1'b1; cs_b_n = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  // One offered byte; returns at the negedge after the accepting edge
  task automatic push(input logic [7:0] b, input bit err);
    host_valid = 1'b1; host_data = b; fs_wr_err = err;
    @(negedge clk);
    host_valid = 1'b0; fs_wr_err = 1'b0;
  endtask

  task automatic pause_cycle(input bit use_b);
    logic m0;
    if (use_b) cs_b_n = 1'b0; else cs_a_n = 1'b0;
    host_valid = 1'b1; host_data = 8'($urandom);
    m0 = cfg_mclk;
    #1;
    chk(host_busy == 1'b1, "R2", "busy while chip select low", host_busy, 1);
    @(negedge clk);
    chk(fs_wr_en == 1'b0, "R2", "no write while paused", fs_wr_en, 0);
    chk(cfg_mclk == m0, "R3", "mclk frozen while paused", cfg_mclk, m0);
    cs_a_n = 1'b1; cs_b_n = 1'b1; host_valid = 1'b0;
  endtask

  task automatic load_payload(input bit with_pauses);
    logic m0;
    for (int i = 0; i < N; i++) begin
      if (with_pauses && ($urandom % 4 == 0)) pause_cycle($urandom % 2 == 1);
      m0 = cfg_mclk;
      push(pl[i], 1'b0);
      chk(fs_wr_en == 1'b1 && int'(fs_addr) == i && fs_wdata == pl[i],
          "R4", "payload write", {fs_wr_en, 4'h0, fs_addr, fs_wdata},
          {1'b1, 4'h0, AW'(i), pl[i]});
      chk(cfg_mclk != m0, "R3", "mclk toggles when running", cfg_mclk, !m0);
    end
  endtask

  task automatic fill_random();
    for (int i = 0; i < N; i++) pl[i] = 8'($urandom);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [15:0] c;
    void'($urandom(32'd4242));
    // R1: reset state
    @(negedge clk);
    chk(init_n == 1 && done_bit == 0 && fs_wr_en == 0 && ds_valid == 0,
        "R1", "outputs in reset", {init_n, done_bit, fs_wr_en, ds_valid}, 4'b1000);
    rst = 1'b0;
    @(negedge clk);
    chk(host_busy == 0 && init_n == 1 && done_bit == 0, "R1", "idle after reset",
        {host_busy, init_n, done_bit}, 3'b010);

    // Last device, good CRC, random pauses
    chain_last = 1'b1;
    fill_random();
    load_payload(1'b1);
    c = ref_crc();
    pause_cycle(1'b0);
    push(c[15:8], 1'b0);
    chk(done_bit == 0 && init_n == 1, "R5", "no done before low CRC byte",
        {done_bit, init_n}, 2'b01);
    push(c[7:0], 1'b0);
    chk(done_bit == 1 && init_n == 1, "R5", "done after CRC match",
        {done_bit, init_n}, 2'b11);
    #1;
    chk(host_busy == 1, "R8", "busy after done on last device", host_busy, 1);
    push(8'h5A, 1'b0);
    chk(fs_wr_en == 0 && ds_valid == 0, "R8", "extra byte ignored",
        {fs_wr_en, ds_valid}, 0);

    // R10: reset in the middle of a stream
    do_reset();
    fill_random();
    for (int i = 0; i < 5; i++) push(pl[i], 1'b0);
    do_reset();
    chk(init_n == 1 && done_bit == 0, "R10", "idle after mid-stream reset",
        {init_n, done_bit}, 2'b10);
    load_payload(1'b0);

    // R6: CRC mismatch
    c = ref_crc();
    push(c[15:8], 1'b0);
    push(c[7:0] ^ 8'h01, 1'b0);
    chk(init_n == 0 && done_bit == 0, "R6", "mismatch drives init low",
        {init_n, done_bit}, 2'b00);
    push(8'hC3, 1'b0);
    repeat (3) @(negedge clk);
    chk(init_n == 0 && done_bit == 0 && fs_wr_en == 0 && host_busy == 1,
        "R6", "stays in configuration", {init_n, done_bit, fs_wr_en, host_busy}, 4'b0001);

    // R9: middle chain member forwards after match
    do_reset();
    chain_last = 1'b0;
    fill_random();
    load_payload(1'b1);
    c = ref_crc();
    push(c[15:8], 1'b0);
    push(c[7:0], 1'b0);
    chk(done_bit == 1, "R9", "done before pass-through", done_bit, 1);
    for (int j = 0; j < 6; j++) begin
      logic [7:0] b;
      b = 8'($urandom);
      chk(ds_valid == 0, "R9", "no strobe without byte", ds_valid, 0);
      push(b, 1'b0);
      chk(ds_valid == 1 && ds_data == b && fs_wr_en == 0, "R9", "forwarded byte",
          {ds_valid, fs_wr_en, ds_data}, {1'b1, 1'b0, b});
      @(negedge clk);
    end

    // R7: write fault in the middle of the payload
    do_reset();
    chain_last = 1'b1;
    fill_random();
    for (int i = 0; i < 3; i++) push(pl[i], 1'b0);
    push(pl[3], 1'b1);
    chk(init_n == 0 && fs_wr_en == 0, "R7", "fault mid payload",
        {init_n, fs_wr_en}, 2'b00);
    push(pl[4], 1'b0);
    chk(fs_wr_en == 0 && init_n == 0, "R7", "no writes after fault",
        {fs_wr_en, init_n}, 2'b00);

    // R7: fault coinciding with a correct final CRC byte
    do_reset();
    fill_random();
    load_payload(1'b0);
    c = ref_crc();
    push(c[15:8], 1'b0);
    push(c[7:0], 1'b1);
    chk(init_n == 0 && done_bit == 0, "R7", "fault beats CRC match",
        {init_n, done_bit}, 2'b00);

    // Directed: all-zero payload gives CRC 0000
    do_reset();
    for (int i = 0; i < N; i++) pl[i] = 8'h00;
    load_payload(1'b0);
    push(8'h00, 1'b0);
    push(8'h00, 1'b0);
    chk(done_bit == 1 && init_n == 1, "R5", "zero payload zero CRC",
        {done_bit, init_n}, 2'b11);

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule